// File: doc/BRIEF.md
# Ping-pong sample window controller

This block is the digital write controller for one channel of a deep switched-capacitor waveform store. A cell address steps through a short front lane every sample clock. Two such lanes take turns: one records while the other is copied into a long circular bank of storage groups. At every lane swap the controller issues one transfer strobe. The strobe carries the lane that has just filled and the storage group that receives it. The group write pointer then moves to the next group that is free.

A trigger protects a window of groups from being overwritten. The window has a programmable length and sits a programmable distance behind the write pointer, which covers the latency of forming the trigger. The protected groups are queued for readout, oldest first. Each acknowledged readout releases its group back to the writer, so reading and recording run at the same time. The bank keeps at least one group for live writing. A trigger that arrives when every other group is already held is rejected and raises an overflow flag.

Top module: `pp_window_ctrl`

## Requirements
- R1: `cell_addr` advances by one every clock, from 0 to LANE_CELLS-1, and then wraps to 0.
- R2: `rec_lane` toggles in the clock cycle where `cell_addr` wraps to 0. In that same cycle, and only then, `xfer_strobe` is high for exactly one cycle, and `xfer_lane` holds the lane that has just finished recording (the opposite of the new `rec_lane`).
- R3: Each strobe presents the current write pointer on `xfer_group`. The pointer starts at group 0 after reset. After each strobe it moves to the next group, modulo NUM_GROUPS, that is not held. It stays where it is if no other group is free.
- R4: A trigger accepted with look-back L and count C holds the groups p-L-C+1 through p-L, modulo NUM_GROUPS, where p is the write pointer when the trigger is accepted. These groups are queued for readout oldest first, one per clock. A field value of 0 is treated as 1.
- R5: Within a trigger window, a group that is already held, or that is the live write group, is skipped. It is neither held again nor queued a second time.
- R6: A trigger that arrives while an earlier window is still being marked has no effect.
- R7: `rd_valid` is high while the readout queue is not empty, and `rd_group` shows the oldest queued group. An `rd_ack` while `rd_valid` is high removes that entry and releases the group, which the write pointer may then use again.
- R8: A trigger that arrives while NUM_GROUPS-1 groups are held is rejected, holds nothing, and sets `overflow`. `overflow` stays high until the next accepted `rd_ack`.
- R9: While reset is asserted, and until the first count after its synchronized release, `cell_addr` is 0, `rec_lane` is 0, and `xfer_strobe`, `rd_valid` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| trig_req | input | 1 | Trigger request; protects a window of groups |
| cfg_lookback | input | log2(NUM_GROUPS) | Distance of the newest held group behind the write pointer (0 means 1) |
| cfg_count | input | log2(NUM_GROUPS) | Number of groups in the trigger window (0 means 1) |
| rd_ack | input | 1 | Acknowledges the group shown on rd_group |
| cell_addr | output | log2(LANE_CELLS) | Cell being written in the recording lane |
| rec_lane | output | 1 | Lane currently recording |
| xfer_strobe | output | 1 | One-cycle transfer strobe at each lane swap |
| xfer_lane | output | 1 | Lane to copy on this strobe |
| xfer_group | output | log2(NUM_GROUPS) | Storage group that receives this transfer |
| rd_valid | output | 1 | A held group is waiting for readout |
| rd_group | output | log2(NUM_GROUPS) | Oldest held group waiting for readout |
| overflow | output | 1 | A trigger was rejected because the bank was full |

## Verification
The bench builds the block with 8-cell lanes and an 8-group bank, so one trigger window can cover the whole bank. With this size the bench can reach, within a few lane periods, the full-bank case, the stuck write pointer and the rejected trigger. The bench keeps its own arithmetic model of the pointer, the held set and the readout order. Against that model it checks every cycle, across windows that wrap through group 0, overlap earlier windows or reach the live group, and across triggers held high for two cycles.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_MARK = 1'b1
  } seq_state_e;
endpackage

// File: rtl/pp_rst_sync.sv
module pp_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_out = out_q;
endmodule

// File: rtl/pp_lane_timer.sv
module pp_lane_timer #(
  parameter int LANE_CELLS = 64,
  parameter int NUM_GROUPS = 512,
  localparam int CW = $clog2(LANE_CELLS),
  localparam int GW = $clog2(NUM_GROUPS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_GROUPS-1:0] held_next,
  output logic [CW-1:0]         cell_addr,
  output logic                  rec_lane,
  output logic                  xfer_strobe,
  output logic                  xfer_lane,
  output logic [GW-1:0]         xfer_group,
  output logic [GW-1:0]         wr_grp
);
  logic [CW-1:0] cell_q, cell_d;
  logic          lane_q, lane_d;
  logic          stb_q, stb_d;
  logic          xlane_q, xlane_d;
  logic [GW-1:0] xgrp_q, xgrp_d;
  logic [GW-1:0] wr_q, wr_d;
  logic          swap;
  logic          found;
  logic [GW-1:0] nxt_free;

  assign swap = (cell_q == CW'(LANE_CELLS - 1));

  // nearest group after the write pointer that will not be held next cycle
  always_comb begin
    found    = 1'b0;
    nxt_free = wr_q;
    for (int i = 1; i < NUM_GROUPS; i++) begin
      if (!found && !held_next[wr_q + GW'(i)]) begin
        found    = 1'b1;
        nxt_free = wr_q + GW'(i);
      end
    end
  end

  always_comb begin
    cell_d  = swap ? '0 : cell_q + CW'(1);
    lane_d  = lane_q;
    stb_d   = swap;
    xlane_d = xlane_q;
    xgrp_d  = xgrp_q;
    wr_d    = wr_q;
    if (swap) begin
      lane_d  = ~lane_q;
      xlane_d = lane_q;
      xgrp_d  = wr_q;
      wr_d    = nxt_free;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cell_q  <= '0;
      lane_q  <= 1'b0;
      stb_q   <= 1'b0;
      xlane_q <= 1'b0;
      xgrp_q  <= '0;
      wr_q    <= '0;
    end else begin
      cell_q  <= cell_d;
      lane_q  <= lane_d;
      stb_q   <= stb_d;
      xlane_q <= xlane_d;
      xgrp_q  <= xgrp_d;
      wr_q    <= wr_d;
    end
  end

  assign cell_addr   = cell_q;
  assign rec_lane    = lane_q;
  assign xfer_strobe = stb_q;
  assign xfer_lane   = xlane_q;
  assign xfer_group  = xgrp_q;
  assign wr_grp      = wr_q;

  assert_cell_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_q == CW'(LANE_CELLS - 1)) |=> (cell_q == '0) && stb_q);
  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);
  assert_lane_opposite_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> (xlane_q != lane_q));
  assert_group_from_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> (xgrp_q == $past(wr_q)));
endmodule

// File: rtl/pp_hold_tracker.sv
module pp_hold_tracker
  import pp_pkg::*;
#(
  parameter int NUM_GROUPS = 512,
  localparam int GW = $clog2(NUM_GROUPS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  trig_req,
  input  logic [GW-1:0]         cfg_lookback,
  input  logic [GW-1:0]         cfg_count,
  input  logic [GW-1:0]         wr_grp,
  input  logic                  rel_valid,
  input  logic [GW-1:0]         rel_grp,
  output logic [NUM_GROUPS-1:0] held_q,
  output logic [NUM_GROUPS-1:0] held_next,
  output logic                  push,
  output logic [GW-1:0]         push_grp,
  output logic                  overflow
);
  seq_state_e    st_q, st_d;
  logic [GW-1:0] cur_q, cur_d;
  logic [GW-1:0] left_q, left_d;
  logic [GW:0]   cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic [GW-1:0] lb, cn, start;
  logic          full, accept, reject, mark_ok, cur_freed;

  assign lb        = (cfg_lookback == '0) ? GW'(1) : cfg_lookback;
  assign cn        = (cfg_count == '0) ? GW'(1) : cfg_count;
  assign start     = wr_grp - lb - cn + GW'(1);
  assign full      = (cnt_q == (GW+1)'(NUM_GROUPS - 1));
  assign accept    = (st_q == SEQ_IDLE) && trig_req && !full;
  assign reject    = (st_q == SEQ_IDLE) && trig_req && full;
  assign cur_freed = rel_valid && (rel_grp == cur_q);
  assign mark_ok   = (st_q == SEQ_MARK) && (cur_q != wr_grp)
                     && (!held_q[cur_q] || cur_freed);

  always_comb begin
    held_next = held_q;
    if (rel_valid) held_next[rel_grp] = 1'b0;
    if (mark_ok)   held_next[cur_q]   = 1'b1;
    cnt_d  = cnt_q + (GW+1)'(mark_ok) - (GW+1)'(rel_valid);
    st_d   = st_q;
    cur_d  = cur_q;
    left_d = left_q;
    if (st_q == SEQ_IDLE) begin
      if (accept) begin
        st_d   = SEQ_MARK;
        cur_d  = start;
        left_d = cn;
      end
    end else begin
      cur_d  = cur_q + GW'(1);
      left_d = left_q - GW'(1);
      if (left_q == GW'(1)) st_d = SEQ_IDLE;
    end
    ovf_d = ovf_q;
    if (reject)         ovf_d = 1'b1;
    else if (rel_valid) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      cur_q  <= '0;
      left_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      held_q <= '0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      left_q <= left_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
      held_q <= held_next;
    end
  end

  assign push     = mark_ok;
  assign push_grp = cur_q;
  assign overflow = ovf_q;

  assert_count_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == (GW+1)'($countones(held_q)));
  assert_never_full_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (GW+1)'(NUM_GROUPS - 1));
  assert_reject_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (st_q == SEQ_IDLE) && ovf_q);
  assert_busy_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_MARK && left_q != GW'(1)) |=> (st_q == SEQ_MARK) && (cur_q == $past(cur_q) + GW'(1)));
endmodule

// File: rtl/pp_rd_queue.sv
module pp_rd_queue #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_data,
  input  logic          pop,
  output logic          valid,
  output logic [AW-1:0] head
);
  logic [AW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]   cnt_q, cnt_d;

  always_comb begin
    wp_d  = push ? wp_q + AW'(1) : wp_q;
    rp_d  = pop  ? rp_q + AW'(1) : rp_q;
    cnt_d = cnt_q + (AW+1)'(push) - (AW+1)'(pop);
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  assign valid = (cnt_q != '0);
  assign head  = mem[rp_q];

  assert_no_push_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q != (AW+1)'(DEPTH)));
  assert_no_pop_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> valid);
endmodule

// File: rtl/pp_window_ctrl.sv
module pp_window_ctrl #(
  parameter int LANE_CELLS = 64,
  parameter int NUM_GROUPS = 512,
  localparam int CW = $clog2(LANE_CELLS),
  localparam int GW = $clog2(NUM_GROUPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_req,
  input  logic [GW-1:0] cfg_lookback,
  input  logic [GW-1:0] cfg_count,
  input  logic          rd_ack,
  output logic [CW-1:0] cell_addr,
  output logic          rec_lane,
  output logic          xfer_strobe,
  output logic          xfer_lane,
  output logic [GW-1:0] xfer_group,
  output logic          rd_valid,
  output logic [GW-1:0] rd_group,
  output logic          overflow
);
  logic                  rst_n_s;
  logic [NUM_GROUPS-1:0] held_q, held_next;
  logic [GW-1:0]         wr_grp;
  logic                  push;
  logic [GW-1:0]         push_grp;
  logic                  rel_valid;

  assign rel_valid = rd_ack && rd_valid;

  pp_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  pp_lane_timer #(.LANE_CELLS(LANE_CELLS), .NUM_GROUPS(NUM_GROUPS)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .held_next   (held_next),
    .cell_addr   (cell_addr),
    .rec_lane    (rec_lane),
    .xfer_strobe (xfer_strobe),
    .xfer_lane   (xfer_lane),
    .xfer_group  (xfer_group),
    .wr_grp      (wr_grp)
  );

  pp_hold_tracker #(.NUM_GROUPS(NUM_GROUPS)) u_hold (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .trig_req     (trig_req),
    .cfg_lookback (cfg_lookback),
    .cfg_count    (cfg_count),
    .wr_grp       (wr_grp),
    .rel_valid    (rel_valid),
    .rel_grp      (rd_group),
    .held_q       (held_q),
    .held_next    (held_next),
    .push         (push),
    .push_grp     (push_grp),
    .overflow     (overflow)
  );

  pp_rd_queue #(.DEPTH(NUM_GROUPS)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .push      (push),
    .push_data (push_grp),
    .pop       (rel_valid),
    .valid     (rd_valid),
    .head      (rd_group)
  );

  assert_live_group_free_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    !held_q[wr_grp]);
  assert_queued_is_held_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_valid |-> held_q[rd_group]);
  assert_strobe_target_free_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    xfer_strobe |-> !held_q[xfer_group]);
endmodule

// File: tb/tb_pp_window_ctrl.sv
`timescale 1ns/1ps
module tb_pp_window_ctrl;
  localparam int LC = 8;
  localparam int NG = 8;
  localparam int CW = $clog2(LC);
  localparam int GW = $clog2(NG);

  logic          clk;
  logic          rst_n;
  logic          trig_req;
  logic [GW-1:0] cfg_lookback;
  logic [GW-1:0] cfg_count;
  logic          rd_ack;
  logic [CW-1:0] cell_addr;
  logic          rec_lane;
  logic          xfer_strobe;
  logic          xfer_lane;
  logic [GW-1:0] xfer_group;
  logic          rd_valid;
  logic [GW-1:0] rd_group;
  logic          overflow;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  int exp_cell, exp_lane, exp_wr, exp_ovf;
  bit held [NG];
  int q [$];

  pp_window_ctrl #(.LANE_CELLS(LC), .NUM_GROUPS(NG)) dut (
    .clk(clk), .rst_n(rst_n), .trig_req(trig_req), .cfg_lookback(cfg_lookback),
    .cfg_count(cfg_count), .rd_ack(rd_ack), .cell_addr(cell_addr), .rec_lane(rec_lane),
    .xfer_strobe(xfer_strobe), .xfer_lane(xfer_lane), .xfer_group(xfer_group),
    .rd_valid(rd_valid), .rd_group(rd_group), .overflow(overflow)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int next_free();
    for (int i = 1; i < NG; i++) begin
      if (!held[(exp_wr + i) % NG]) return (exp_wr + i) % NG;
    end
    return exp_wr;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    exp_cell = (exp_cell + 1) % LC;
    chk("R1 cell_addr", int'(cell_addr), exp_cell);
    if (exp_cell == 0) begin
      chk("R2 strobe at swap", int'(xfer_strobe), 1);
      chk("R2 xfer_lane", int'(xfer_lane), exp_lane);
      exp_lane ^= 1;
      chk("R2 rec_lane", int'(rec_lane), exp_lane);
      chk("R3 xfer_group", int'(xfer_group), exp_wr);
      exp_wr = next_free();
    end else begin
      chk("R2 strobe idle", int'(xfer_strobe), 0);
    end
    chk("R8 overflow", int'(overflow), exp_ovf);
  endtask

  task automatic wait_swap();
    tick();
    while (exp_cell != 0) tick();
  endtask

  // called when exp_cell == 0 so no swap falls inside the marking cycles
  task automatic trigger(int l, int c, bit twice);
    int lb, cn, cnt;
    lb = (l == 0) ? 1 : l;
    cn = (c == 0) ? 1 : c;
    cnt = 0;
    for (int g = 0; g < NG; g++) cnt += held[g];
    if (cnt == NG - 1) begin
      exp_ovf = 1;
    end else begin
      for (int k = 0; k < cn; k++) begin
        int g;
        g = ((exp_wr - lb - cn + 1 + k) % NG + NG) % NG;
        if (g != exp_wr && !held[g]) begin
          held[g] = 1;
          q.push_back(g);
        end
      end
    end
    cfg_lookback = GW'(l);
    cfg_count    = GW'(c);
    trig_req     = 1'b1;
    tick();
    if (twice) tick();
    trig_req = 1'b0;
  endtask

  task automatic ack();
    chk("R7 rd_valid", int'(rd_valid), 1);
    chk("R7 rd_group order", int'(rd_group), q[0]);
    held[q[0]] = 0;
    void'(q.pop_front());
    exp_ovf = 0;
    rd_ack = 1'b1;
    tick();
    rd_ack = 1'b0;
  endtask

  task automatic drain();
    while (q.size() > 0) begin
      ack();
      tick();
    end
    chk("R7 queue empty", int'(rd_valid), 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; trig_req = 1'b0; rd_ack = 1'b0;
    cfg_lookback = '0; cfg_count = '0;
    for (int g = 0; g < NG; g++) held[g] = 0;
    exp_cell = 0; exp_lane = 0; exp_wr = 0; exp_ovf = 0;
    repeat (3) @(negedge clk);
    // R9: state during reset
    chk("R9 cell in reset", int'(cell_addr), 0);
    chk("R9 strobe in reset", int'(xfer_strobe), 0);
    chk("R9 rd_valid in reset", int'(rd_valid), 0);
    chk("R9 overflow in reset", int'(overflow), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R9 cell after release", int'(cell_addr), 0);
    chk("R9 lane after release", int'(rec_lane), 0);

    // R1 R2 R3: free-running lanes
    repeat (3) wait_swap();

    // R4: basic window, then pointer skips held groups
    trigger(2, 3, 0);
    repeat (3) wait_swap();
    drain();
    wait_swap();

    // R4: zero fields count as one
    trigger(0, 0, 0);
    wait_swap();
    drain();
    wait_swap();

    // R6: trigger held for two cycles
    trigger(1, 2, 1);
    wait_swap();
    drain();
    wait_swap();

    // R5: overlapping windows and a window reaching the live group
    trigger(1, 3, 0);
    wait_swap();
    trigger(1, 3, 0);
    wait_swap();
    drain();
    wait_swap();
    trigger(3, 7, 0);
    repeat (2) wait_swap();
    drain();
    wait_swap();

    // R8: full bank, stuck pointer, rejection and clearing
    trigger(1, 7, 0);
    repeat (2) wait_swap();
    trigger(1, 1, 0);
    wait_swap();
    drain();
    repeat (2) wait_swap();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule